// File: doc/BRIEF.md
# Host Memory Port with Strobe Handshake

This block is the 16-bit parallel host port of a time-slot switch. A host starts an access by pulling both chip-select (`cs_n`) and data-strobe (`ds_n`) low with the address, the direction bit and, for writes, the data already stable. The port answers by driving the active-low acknowledge `ack_n` low once the access has been carried out, and it raises `ack_n` again after the host releases either strobe. The top address bit chooses between a small register bank and the memory space. Inside the memory space the next bit down chooses between the connection memory, which the host may read and write, and the data memory. The data memory is filled by the switching fabric through its own write port and is read-only to the host.

The access engine runs on the switching clock `sys_clk`. A second, always-running clock `aux_clk` drives a watchdog that watches a heartbeat from the switching domain. When the heartbeat stops, the acknowledge is taken from a small fallback state machine on `aux_clk`. This means the bus handshake still completes, although no memory is touched and the read data has no meaning. After `ack_n` rises, a strobe that returns within a short guard window counts as a continuation of the same access: the acknowledge is given again, but the access is not carried out a second time.

Access engine states: `S_IDLE` goes to `S_ISSUE` when the synchronized strobe is seen and the address, direction and data are captured. `S_ISSUE` goes to `S_FETCH` while a write, if any, is committed. `S_FETCH` goes to `S_ACK` after the read data is latched. `S_ACK` goes to `S_GAP` when the strobe drops. In `S_GAP`, a returning strobe leads back to `S_ACK` (continuation). If the window runs out first, the engine goes to `S_IDLE`. Fallback states: `FB_IDLE` goes to `FB_HOLD` when the strobe is seen on `aux_clk`, and `FB_HOLD` returns to `FB_IDLE` when the strobe drops.

Top module: `hostport_top`

## Requirements
- R1: During and right after reset, `ack_n` is 1 and `rdata` is 16'h0000.
- R2: Addresses with bit 14 = 0 reach 8 read/write registers, indexed by address bits [2:0].
- R3: Addresses with bit 14 = 1 and bit 13 = 0 reach the 64-word connection memory, indexed by address bits [5:0]. Each word can be written and read back.
- R4: Addresses with bit 14 = 1 and bit 13 = 1 read the 64-word data memory loaded through the fabric port (`fab_we`, `fab_addr`, `fab_wdata`). Host writes there leave the contents unchanged.
- R5: For each access with both strobes low, `ack_n` goes low. It returns high after either `cs_n` or `ds_n` alone goes high.
- R6: `rd_wr_n` = 1 selects a read and 0 selects a write. During a read, `rdata` holds the addressed word for as long as `ack_n` stays low.
- R7: A strobe that returns within GAP_CYC (6) switching-clock cycles of the acknowledge release is a continuation. `ack_n` goes low again, no write is made, and `rdata` keeps the earlier value.
- R8: Once the guard window has passed, a new strobe starts a separate access that uses its own address and data.
- R9: If `sys_clk` stops for longer than the watchdog window, `ack_n` still goes low for each access and rises after the strobes are released.
- R10: Host writes made while `sys_clk` is stopped have no effect on memory contents.
- R11: When `sys_clk` starts again, the watchdog clears and ordinary accesses read and write as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Switching clock; may stop |
| aux_clk | input | 1 | Free-running backup clock for the watchdog and fallback acknowledge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 15 | Host address; bit 14 space select, bit 13 memory select |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| ack_n | output | 1 | Data-transfer acknowledge, active low |
| fab_we | input | 1 | Fabric write enable for the data memory |
| fab_addr | input | 6 | Fabric write address |
| fab_wdata | input | 16 | Fabric write data |

## Verification
A wrong region decode or a write that leaks through appears at the next read-back of a swept location. Every register, connection word and data word is written and then read back. If the access engine gets stuck in a state, `ack_n` stays low or never falls, and the bench sees this within a few microseconds. A guard window that is mishandled shows up in the first read after a continuation as a changed memory word or a new `rdata` value. A watchdog that does not switch over shows up as a missing acknowledge about 100 ns after the switching clock stops.

// File: rtl/hp_pkg.sv
`timescale 1ns/100ps
package hp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_FETCH,
        S_ACK,
        S_GAP
    } acc_state_t;

    typedef enum logic {
        FB_IDLE,
        FB_HOLD
    } fb_state_t;

    typedef enum logic [1:0] {
        RG_REG,
        RG_CM,
        RG_DM
    } region_t;

    function automatic region_t decode_region(input logic space_bit, input logic dm_bit);
        if (!space_bit)
            return RG_REG;
        else if (dm_bit)
            return RG_DM;
        else
            return RG_CM;
    endfunction

endpackage

// File: rtl/hp_sync.sv
`timescale 1ns/100ps
module hp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hp_sram.sv
`timescale 1ns/100ps
module hp_sram #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hp_clkwatch.sv
`timescale 1ns/100ps
module hp_clkwatch #(
    parameter int HB_BITS  = 3,
    parameter int WD_LIMIT = 8
) (
    input  logic sys_clk,
    input  logic aux_clk,
    input  logic rst_n,
    output logic lost
);
    localparam int CW = $clog2(WD_LIMIT + 1);

    logic [HB_BITS-1:0] hb_cnt;
    logic               hb_sync;
    logic               hb_prev;
    logic               beat;
    logic [CW-1:0]      silence;

    // heartbeat in the switching domain
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) hb_cnt <= '0;
        else        hb_cnt <= hb_cnt + 1'b1;
    end

    hp_sync #(.W(1), .STAGES(2)) u_hb_sync (
        .clk   (aux_clk),
        .rst_n (rst_n),
        .d     (hb_cnt[HB_BITS-1]),
        .q     (hb_sync)
    );

    always_ff @(posedge aux_clk or negedge rst_n) begin
        if (!rst_n) hb_prev <= 1'b0;
        else        hb_prev <= hb_sync;
    end

    assign beat = hb_sync ^ hb_prev;

    always_ff @(posedge aux_clk or negedge rst_n) begin
        if (!rst_n)
            silence <= '0;
        else if (beat)
            silence <= '0;
        else if (silence != CW'(WD_LIMIT))
            silence <= silence + 1'b1;
    end

    assign lost = (silence == CW'(WD_LIMIT));

    p_wdog_bound_r9: assert property (@(posedge aux_clk) disable iff (!rst_n)
        silence <= CW'(WD_LIMIT));

    p_beat_clears_r11: assert property (@(posedge aux_clk) disable iff (!rst_n)
        beat |=> !lost);
endmodule

// File: rtl/hp_fallback_ack.sv
`timescale 1ns/100ps
module hp_fallback_ack
    import hp_pkg::*;
(
    input  logic aux_clk,
    input  logic rst_n,
    input  logic strb_a,
    output logic fb_ack_n
);
    fb_state_t fb_state, fb_nxt;

    always_comb begin
        fb_nxt = fb_state;
        unique case (fb_state)
            FB_IDLE: if (strb_a)  fb_nxt = FB_HOLD;
            FB_HOLD: if (!strb_a) fb_nxt = FB_IDLE;
            default:              fb_nxt = FB_IDLE;
        endcase
    end

    always_ff @(posedge aux_clk or negedge rst_n) begin
        if (!rst_n) fb_state <= FB_IDLE;
        else        fb_state <= fb_nxt;
    end

    always_ff @(posedge aux_clk or negedge rst_n) begin
        if (!rst_n) fb_ack_n <= 1'b1;
        else        fb_ack_n <= (fb_nxt != FB_HOLD);
    end

    p_fb_release_r9: assert property (@(posedge aux_clk) disable iff (!rst_n)
        !strb_a |=> fb_ack_n);
endmodule

// File: rtl/hp_access_fsm.sv
`timescale 1ns/100ps
module hp_access_fsm
    import hp_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 15,
    parameter int MEM_AW  = 6,
    parameter int GAP_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb,
    input  logic              rd_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic              reg_we,
    output logic              cm_we,
    output logic [MEM_AW-1:0] m_addr,
    output logic [DW-1:0]     m_wdata,
    input  logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     cm_rdata,
    input  logic [DW-1:0]     dm_rdata,
    output logic              ack_n,
    output logic [DW-1:0]     rdata
);
    localparam int GW = $clog2(GAP_CYC + 1);

    acc_state_t        state, nxt;
    logic              cap_rd;
    logic              cap_space;
    logic              cap_dm;
    logic [MEM_AW-1:0] cap_idx;
    logic [DW-1:0]     cap_wdata;
    logic [GW-1:0]     gap_cnt;
    region_t           region;
    logic              host_wr;
    logic              unused_hi;

    assign unused_hi = ^addr_i[AW-3:MEM_AW];

    assign region  = decode_region(cap_space, cap_dm);
    assign host_wr = (state == S_ISSUE) && !cap_rd;
    assign reg_we  = host_wr && (region == RG_REG);
    assign cm_we   = host_wr && (region == RG_CM);
    assign m_addr  = cap_idx;
    assign m_wdata = cap_wdata;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (strb) nxt = S_ISSUE;
            S_ISSUE: nxt = S_FETCH;
            S_FETCH: nxt = S_ACK;
            S_ACK:   if (!strb) nxt = S_GAP;
            S_GAP: begin
                if (strb)
                    nxt = S_ACK;
                else if (gap_cnt == GW'(GAP_CYC - 1))
                    nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // capture of the request and guard-window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_rd    <= 1'b1;
            cap_space <= 1'b0;
            cap_dm    <= 1'b0;
            cap_idx   <= '0;
            cap_wdata <= '0;
            gap_cnt   <= '0;
        end else begin
            if (state == S_IDLE && strb) begin
                cap_rd    <= rd_i;
                cap_space <= addr_i[AW-1];
                cap_dm    <= addr_i[AW-2];
                cap_idx   <= addr_i[MEM_AW-1:0];
                cap_wdata <= wdata_i;
            end
            if (state == S_GAP) gap_cnt <= gap_cnt + 1'b1;
            else                gap_cnt <= '0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_n <= 1'b1;
            rdata <= '0;
        end else begin
            ack_n <= (nxt != S_ACK);
            if (state == S_FETCH && cap_rd) begin
                unique case (region)
                    RG_REG:  rdata <= reg_rdata;
                    RG_CM:   rdata <= cm_rdata;
                    RG_DM:   rdata <= dm_rdata;
                    default: rdata <= '0;
                endcase
            end
        end
    end

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK && !strb) |=> ack_n);

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK) |=> $stable(rdata));

    p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> !(reg_we || cm_we));
endmodule

// File: rtl/hostport_top.sv
`timescale 1ns/100ps
module hostport_top #(
    parameter int DW       = 16,
    parameter int AW       = 15,
    parameter int REG_AW   = 3,
    parameter int MEM_AW   = 6,
    parameter int GAP_CYC  = 6,
    parameter int HB_BITS  = 3,
    parameter int WD_LIMIT = 8
) (
    input  logic              sys_clk,
    input  logic              aux_clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rd_wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              ack_n,
    input  logic              fab_we,
    input  logic [MEM_AW-1:0] fab_addr,
    input  logic [DW-1:0]     fab_wdata
);
    logic              strb_raw;
    logic              strb_s;
    logic              strb_a;
    logic              reg_we;
    logic              cm_we;
    logic [MEM_AW-1:0] m_addr;
    logic [DW-1:0]     m_wdata;
    logic [DW-1:0]     reg_rdata;
    logic [DW-1:0]     cm_rdata;
    logic [DW-1:0]     dm_rdata;
    logic              main_ack_n;
    logic              fb_ack_n;
    logic              clk_lost;

    assign strb_raw = !cs_n && !ds_n;

    hp_sync #(.W(1), .STAGES(2)) u_sync_sys (
        .clk (sys_clk), .rst_n (rst_n), .d (strb_raw), .q (strb_s)
    );

    hp_sync #(.W(1), .STAGES(2)) u_sync_aux (
        .clk (aux_clk), .rst_n (rst_n), .d (strb_raw), .q (strb_a)
    );

    hp_access_fsm #(
        .DW (DW), .AW (AW), .MEM_AW (MEM_AW), .GAP_CYC (GAP_CYC)
    ) u_access (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .strb      (strb_s),
        .rd_i      (rd_wr_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .reg_we    (reg_we),
        .cm_we     (cm_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .reg_rdata (reg_rdata),
        .cm_rdata  (cm_rdata),
        .dm_rdata  (dm_rdata),
        .ack_n     (main_ack_n),
        .rdata     (rdata)
    );

    hp_sram #(.DW (DW), .AW (REG_AW)) u_regs (
        .clk   (sys_clk),
        .we    (reg_we),
        .waddr (m_addr[REG_AW-1:0]),
        .wdata (m_wdata),
        .raddr (m_addr[REG_AW-1:0]),
        .rdata (reg_rdata)
    );

    hp_sram #(.DW (DW), .AW (MEM_AW)) u_conn_mem (
        .clk   (sys_clk),
        .we    (cm_we),
        .waddr (m_addr),
        .wdata (m_wdata),
        .raddr (m_addr),
        .rdata (cm_rdata)
    );

    hp_sram #(.DW (DW), .AW (MEM_AW)) u_data_mem (
        .clk   (sys_clk),
        .we    (fab_we),
        .waddr (fab_addr),
        .wdata (fab_wdata),
        .raddr (m_addr),
        .rdata (dm_rdata)
    );

    hp_clkwatch #(.HB_BITS (HB_BITS), .WD_LIMIT (WD_LIMIT)) u_watch (
        .sys_clk (sys_clk),
        .aux_clk (aux_clk),
        .rst_n   (rst_n),
        .lost    (clk_lost)
    );

    hp_fallback_ack u_fallback (
        .aux_clk  (aux_clk),
        .rst_n    (rst_n),
        .strb_a   (strb_a),
        .fb_ack_n (fb_ack_n)
    );

    assign ack_n = clk_lost ? fb_ack_n : main_ack_n;
endmodule

// File: tb/hostport_top_tb.sv
`timescale 1ns/100ps
module hostport_top_tb;
    logic        sys_clk = 1'b0;
    logic        aux_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rd_wr_n = 1'b1;
    logic [14:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack_n;
    logic        fab_we = 1'b0;
    logic [5:0]  fab_addr = '0;
    logic [15:0] fab_wdata = '0;
    bit          sys_en = 1'b1;
    int          n_chk = 0;
    int          n_bad = 0;

    initial forever begin
        #2.5;
        if (sys_en) sys_clk = ~sys_clk;
    end

    initial begin
        #0.3;
        forever #5 aux_clk = ~aux_clk;
    end

    hostport_top u_dut (
        .sys_clk (sys_clk), .aux_clk (aux_clk), .rst_n (rst_n),
        .cs_n (cs_n), .ds_n (ds_n), .rd_wr_n (rd_wr_n),
        .addr (addr), .wdata (wdata), .rdata (rdata), .ack_n (ack_n),
        .fab_we (fab_we), .fab_addr (fab_addr), .fab_wdata (fab_wdata)
    );

    function automatic logic [15:0] reg_pat(int i);
        return 16'hA5C3 ^ 16'(i * 16'h1111);
    endfunction
    function automatic logic [15:0] cm_pat(int i);
        return 16'h1357 + 16'(i * 16'h0403);
    endfunction
    function automatic logic [15:0] dm_pat(int i);
        return ~(16'(i * 16'h0211) + 16'h00F0);
    endfunction
    function automatic logic [14:0] reg_a(int i);
        return 15'(i & 7);
    endfunction
    function automatic logic [14:0] cm_a(int i);
        return 15'h4000 | 15'(i & 63);
    endfunction
    function automatic logic [14:0] dm_a(int i);
        return 15'h6000 | 15'(i & 63);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host access; cont=1 leaves only a short pause so the next one is a continuation
    task automatic host_op(input bit rd, input logic [14:0] a, input logic [15:0] d,
                           input bit ds_first, input bit cont,
                           output logic [15:0] val, output bit ok);
        int t;
        ok = 1'b1;
        rd_wr_n = rd; addr = a; wdata = d;
        #2;
        cs_n = 1'b0; ds_n = 1'b0;
        t = 0;
        while (ack_n !== 1'b0 && t < 3000) begin #1; t++; end
        if (ack_n !== 1'b0) ok = 1'b0;
        #1;
        val = rdata;
        if (ds_first) ds_n = 1'b1; else cs_n = 1'b1;
        t = 0;
        while (ack_n !== 1'b1 && t < 3000) begin #1; t++; end
        if (ack_n !== 1'b1) ok = 1'b0;
        cs_n = 1'b1; ds_n = 1'b1;
        if (cont) #2; else #80;
    endtask

    task automatic fab_load();
        for (int i = 0; i < 64; i++) begin
            @(negedge sys_clk);
            fab_we = 1'b1; fab_addr = 6'(i); fab_wdata = dm_pat(i);
        end
        @(negedge sys_clk);
        fab_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        logic [15:0] v;
        bit ok;

        #20;
        check("R1 ack_n in reset", {15'd0, ack_n}, 16'h0001);
        check("R1 rdata in reset", rdata, 16'h0000);
        #23 rst_n = 1'b1;
        #100;
        check("R1 ack_n after reset", {15'd0, ack_n}, 16'h0001);
        check("R1 rdata after reset", rdata, 16'h0000);

        // R2: register bank sweep, both release orders (R5)
        for (int i = 0; i < 8; i++) begin
            host_op(1'b0, reg_a(i), reg_pat(i), i[0], 1'b0, v, ok);
            check("R5 register write handshake", {15'd0, ok}, 16'h0001);
        end
        for (int i = 0; i < 8; i++) begin
            host_op(1'b1, reg_a(i), 16'h0000, ~i[0], 1'b0, v, ok);
            check("R5 register read handshake", {15'd0, ok}, 16'h0001);
            check("R2 register readback", v, reg_pat(i));
        end

        // R3: connection memory sweep
        for (int i = 0; i < 64; i++) host_op(1'b0, cm_a(i), cm_pat(i), i[1], 1'b0, v, ok);
        for (int i = 0; i < 64; i++) begin
            host_op(1'b1, cm_a(i), 16'hFFFF, i[0], 1'b0, v, ok);
            check("R3 connection readback", v, cm_pat(i));
        end

        // R4: data memory loaded by fabric, host writes ignored
        fab_load();
        for (int i = 0; i < 64; i++) begin
            host_op(1'b0, dm_a(i), ~dm_pat(i), 1'b0, 1'b0, v, ok);
            host_op(1'b1, dm_a(i), 16'h0000, 1'b1, 1'b0, v, ok);
            check("R4 data memory read-only", v, dm_pat(i));
        end
        // R6: register readback unaffected by memory traffic
        host_op(1'b1, reg_a(3), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R6 read after memory traffic", v, reg_pat(3));

        // R7: write continuation must not commit the second write
        host_op(1'b0, cm_a(5), 16'hBEEF, 1'b0, 1'b1, v, ok);
        host_op(1'b0, cm_a(5), 16'h0BAD, 1'b0, 1'b0, v, ok);
        check("R7 continuation acknowledged", {15'd0, ok}, 16'h0001);
        host_op(1'b1, cm_a(5), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R7 continuation write suppressed", v, 16'hBEEF);
        // R7: read continuation keeps earlier data
        host_op(1'b1, reg_a(1), 16'h0000, 1'b1, 1'b1, v, ok);
        check("R6 first read", v, reg_pat(1));
        host_op(1'b1, reg_a(2), 16'h0000, 1'b1, 1'b0, v, ok);
        check("R7 continuation read data", v, reg_pat(1));
        // R8: separate access after the window
        host_op(1'b1, reg_a(2), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R8 separate access", v, reg_pat(2));
        host_op(1'b0, cm_a(5), 16'h2468, 1'b0, 1'b0, v, ok);
        host_op(1'b1, cm_a(5), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R8 separate write", v, 16'h2468);

        // R9/R10: stop switching clock
        sys_en = 1'b0;
        #400;
        host_op(1'b0, cm_a(7), 16'hDEAD, 1'b0, 1'b0, v, ok);
        check("R9 ack without clock (write)", {15'd0, ok}, 16'h0001);
        host_op(1'b1, cm_a(7), 16'h0000, 1'b1, 1'b0, v, ok);
        check("R9 ack without clock (read)", {15'd0, ok}, 16'h0001);
        host_op(1'b0, reg_a(4), 16'h5555, 1'b1, 1'b0, v, ok);
        check("R9 ack without clock (reg write)", {15'd0, ok}, 16'h0001);

        // R11: restart
        sys_en = 1'b1;
        #400;
        host_op(1'b1, cm_a(7), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R10 connection write during loss ignored", v, cm_pat(7));
        host_op(1'b1, reg_a(4), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R10 register write during loss ignored", v, reg_pat(4));
        host_op(1'b0, cm_a(7), 16'h7777, 1'b0, 1'b0, v, ok);
        host_op(1'b1, cm_a(7), 16'h0000, 1'b0, 1'b0, v, ok);
        check("R11 access after restart", v, 16'h7777);
        check("R11 handshake after restart", {15'd0, ok}, 16'h0001);

        summary();
    end
endmodule